// File: doc/BRIEF.md
# Destination MAC Address Filter

This block sits on the receive path of an Ethernet MAC. It decides, for each incoming frame, whether to keep it or drop it, based on the 48-bit destination address. The frame arrives one byte per cycle, first byte first. The block collects the first six bytes and compares them with a table of exact-match entries. The default table has 17 entries, and each entry has its own enable. One cycle after the sixth byte, the block raises a one-cycle decision pulse, so the decision is known before the payload moves on. A promiscuous input accepts every full-length frame and ignores the table.

Software fills the table through a simple write-only word interface. Each entry takes two words: a 16-bit word with the two leading address bytes and a 32-bit word with the remaining four bytes. A single mask word enables the entries. Entry 0 is enabled by the highest mask bit, and later entries by lower bits. By convention, software places the broadcast address in entry 0 and the station address in entry 1. When software needs more entries than the table holds, it switches to promiscuous mode. Writes go to a staging copy of the table. The comparison uses an active copy that is reloaded from the staging copy at each start of frame. A frame that is already being compared therefore never sees a partial update.

Top module: `dst_addr_filter`

## Requirements
- R1: After reset, `dec_valid` and `dec_accept` are low, every table entry is zero and the enable mask is zero, so every frame is dropped.
- R2: Register layout. A write is decoded only when `cfg_addr[1:0]` is 0. For entry k, the word at byte offset 0x04+8k holds address byte 0 in bits 15:8 and byte 1 in bits 7:0. The word at 0x08+8k holds byte 2 in bits 31:24 down to byte 5 in bits 7:0.
- R3: The enable mask is at offset 0x00. Entry k is enabled by mask bit NUM_ENTRIES-1-k, which is bit 16-k with the default 17 entries. A mask of zero disables all exact matching.
- R4: Address byte 0 is the first byte of the frame. A frame is accepted when at least one enabled entry equals all 48 bits of its destination address. Otherwise it is dropped.
- R5: `dec_valid` is a one-cycle pulse in the cycle after the sixth frame byte is sampled. `dec_accept` carries the decision in that cycle and is low whenever `dec_valid` is low.
- R6: If `promisc` is high in the cycle the sixth byte is sampled, the frame is accepted whatever the table holds.
- R7: A frame that ends (`rx_eof`) before its sixth byte gives a `dec_valid` pulse with `dec_accept` low in the cycle after its last byte, even when `promisc` is high.
- R8: Writes to the table or the mask take effect at the next start of frame. A write in the same cycle as a start-of-frame byte waits for the start of frame after that.
- R9: Cycles with `rx_valid` low carry no byte. Bytes after the decision or after `rx_eof`, up to the next `rx_sof`, produce no decision. A new `rx_sof` restarts address capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW (8) | Byte address of the register write |
| cfg_wdata | input | 32 | Register write data |
| promisc | input | 1 | Accept every full-length frame |
| rx_valid | input | 1 | A frame byte is present on `rx_data` |
| rx_sof | input | 1 | This byte is the first of a frame |
| rx_eof | input | 1 | This byte is the last of a frame |
| rx_data | input | 8 | Frame byte |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | Accept (1) or drop (0), valid with `dec_valid` |

## Verification
The hardest case to reach from the ports is a table rewrite that overlaps the comparison of a frame. The stimulus targets three points: a write between the start-of-frame byte and the sixth byte, a write on exactly the start-of-frame cycle, and the frame after each of these. Every check is made against a behavioural model that tracks both the staging table and the active table. The stimulus also covers:
- frames broken up by idle cycles;
- restarts in the middle of an address;
- one-byte frames and frames of exactly six bytes;
- stray bytes after end of frame;
- the last table entry, which is enabled by mask bit 0.

// File: rtl/daf_pkg.sv
package daf_pkg;
   localparam int MAC_BYTES = 6;
   localparam int MAC_W     = 8 * MAC_BYTES;
   typedef logic [MAC_W-1:0] mac_t;
endpackage

// File: rtl/daf_regs.sv
module daf_regs
   import daf_pkg::*;
#(
   parameter int NUM = 17,
   parameter int AW  = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [AW-1:0]        cfg_addr,
   input  logic [31:0]          cfg_wdata,
   input  logic                 frame_start,
   output mac_t [NUM-1:0]       act_tbl,
   output logic [NUM-1:0]       act_mask,
   output logic [NUM-1:0]       act_en
);
   localparam int IW = AW - 2;

   logic [IW-1:0]  widx;
   logic           wr_ok;
   logic [NUM-1:0] stg_mask;
   mac_t [NUM-1:0] stg_tbl;

   assign widx  = cfg_addr[AW-1:2];
   assign wr_ok = cfg_we && (cfg_addr[1:0] == 2'b00);

   always_ff @(posedge clk) begin
      if (!rst_n)
         stg_mask <= '0;
      else if (wr_ok && widx == '0)
         stg_mask <= cfg_wdata[NUM-1:0];
   end

   for (genvar g = 0; g < NUM; g++) begin : g_ent
      logic [15:0] hi_q;
      logic [31:0] lo_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
         end else begin
            if (wr_ok && widx == IW'(2 * g + 1))
               hi_q <= cfg_wdata[15:0];
            if (wr_ok && widx == IW'(2 * g + 2))
               lo_q <= cfg_wdata;
         end
      end
      assign stg_tbl[g] = {hi_q, lo_q};
      assign act_en[g]  = act_mask[NUM-1-g];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_tbl  <= '0;
         act_mask <= '0;
      end else if (frame_start) begin
         act_tbl  <= stg_tbl;
         act_mask <= stg_mask;
      end
   end

   // R8
   table_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> ($stable(act_tbl) && $stable(act_mask)));
endmodule

// File: rtl/daf_capture.sv
module daf_capture
   import daf_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_valid,
   input  logic       rx_sof,
   input  logic       rx_eof,
   input  logic [7:0] rx_data,
   output mac_t       da_full,
   output logic       sixth_byte,
   output logic       short_end,
   output logic       frame_start,
   output logic       cap_idle
);
   localparam int CW = $clog2(MAC_BYTES + 1);
   localparam logic [CW-1:0] IDLE = CW'(MAC_BYTES);
   localparam logic [CW-1:0] LAST = CW'(MAC_BYTES - 1);

   logic [CW-1:0]        cnt_q;
   logic [CW-1:0]        idx;
   logic                 live;
   logic [MAC_W-9:0]     shreg_q;

   assign frame_start = rx_valid && rx_sof;
   assign idx         = rx_sof ? '0 : cnt_q;
   assign live        = rx_valid && (rx_sof || cnt_q < IDLE);
   assign sixth_byte  = live && idx == LAST;
   assign short_end   = live && rx_eof && idx < LAST;
   assign da_full     = {shreg_q, rx_data};
   assign cap_idle    = cnt_q == IDLE;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= IDLE;
         shreg_q <= '0;
      end else if (live) begin
         shreg_q <= {shreg_q[MAC_W-17:0], rx_data};
         cnt_q   <= (rx_eof || idx == LAST) ? IDLE : idx + 1'b1;
      end
   end
endmodule

// File: rtl/daf_match.sv
module daf_match
   import daf_pkg::*;
#(
   parameter int NUM = 17
) (
   input  mac_t           da,
   input  mac_t [NUM-1:0] tbl,
   input  logic [NUM-1:0] en,
   output logic           hit
);
   logic [NUM-1:0] eq;

   for (genvar g = 0; g < NUM; g++) begin : g_cmp
      assign eq[g] = en[g] && (tbl[g] == da);
   end

   assign hit = |eq;
endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
   import daf_pkg::*;
#(
   parameter int NUM_ENTRIES = 17,
   parameter int CFG_AW      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   input  logic              promisc,
   input  logic              rx_valid,
   input  logic              rx_sof,
   input  logic              rx_eof,
   input  logic [7:0]        rx_data,
   output logic              dec_valid,
   output logic              dec_accept
);
   if (NUM_ENTRIES < 1 || NUM_ENTRIES > 32) begin : g_bad_num
      $error("NUM_ENTRIES must lie in 1..32");
   end
   if ((1 << CFG_AW) < 4 * (2 * NUM_ENTRIES + 1)) begin : g_bad_aw
      $error("CFG_AW too narrow for the register map");
   end

   mac_t                   da_full;
   logic                   sixth_byte, short_end, frame_start, cap_idle;
   mac_t [NUM_ENTRIES-1:0] act_tbl;
   logic [NUM_ENTRIES-1:0] act_mask, act_en;
   logic                   hit;

   daf_capture u_cap (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
      .rx_eof(rx_eof), .rx_data(rx_data), .da_full(da_full),
      .sixth_byte(sixth_byte), .short_end(short_end),
      .frame_start(frame_start), .cap_idle(cap_idle));

   daf_regs #(.NUM(NUM_ENTRIES), .AW(CFG_AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .frame_start(frame_start),
      .act_tbl(act_tbl), .act_mask(act_mask), .act_en(act_en));

   daf_match #(.NUM(NUM_ENTRIES)) u_match (
      .da(da_full), .tbl(act_tbl), .en(act_en), .hit(hit));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_valid  <= 1'b0;
         dec_accept <= 1'b0;
      end else begin
         dec_valid  <= sixth_byte || short_end;
         dec_accept <= sixth_byte && (promisc || hit);
      end
   end

   // R6
   promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sixth_byte && promisc) |=> (dec_valid && dec_accept));
   // R7
   short_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      short_end |=> (dec_valid && !dec_accept));
   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_idle && !frame_start) |=> !dec_valid);
   // R3
   mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sixth_byte && !promisc && act_mask == '0) |=> !dec_accept);
endmodule

// File: tb/dst_addr_filter_tb.sv
module dst_addr_filter_tb;
   localparam int NUM = 17;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        promisc = 1'b0;
   logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        dec_valid, dec_accept;

   always #10 clk = ~clk;

   dst_addr_filter u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .promisc(promisc), .rx_valid(rx_valid),
      .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
      .dec_valid(dec_valid), .dec_accept(dec_accept));

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   // behavioural reference state
   logic [15:0] s_hi[NUM], a_hi[NUM];
   logic [31:0] s_lo[NUM], a_lo[NUM];
   logic [NUM-1:0] s_en = '0, a_en = '0;
   int          cnt = 6;
   logic [47:0] da = '0;
   logic        exp_v = 0, exp_a = 0;
   string       exp_tag = "R1";
   logic        p_we = 0;
   logic [7:0]  p_addr = '0;
   logic [31:0] p_data = '0;

   function automatic logic model_hit(logic [47:0] a);
      for (int k = 0; k < NUM; k++)
         if (a_en[NUM-1-k] && {a_hi[k], a_lo[k]} == a) return 1'b1;
      return 1'b0;
   endfunction

   task automatic cyc(input logic v, s, e, input logic [7:0] d, input string tag);
      int idx;
      n_chk++;
      if (dec_valid !== exp_v || dec_accept !== exp_a) begin
         n_fail++;
         $display("FAIL %s: valid/accept = %b/%b, expected %b/%b",
                  exp_tag, dec_valid, dec_accept, exp_v, exp_a);
      end
      rx_valid = v; rx_sof = s; rx_eof = e; rx_data = d;
      cfg_we = p_we; cfg_addr = p_addr; cfg_wdata = p_data;
      exp_v = 0; exp_a = 0; exp_tag = tag;
      if (v && s) begin
         for (int k = 0; k < NUM; k++) begin a_hi[k] = s_hi[k]; a_lo[k] = s_lo[k]; end
         a_en = s_en;
      end
      if (v && (s || cnt < 6)) begin
         idx = s ? 0 : cnt;
         da = {da[39:0], d};
         if (idx == 5) begin exp_v = 1; exp_a = promisc || model_hit(da); end
         else if (e) exp_v = 1;
         cnt = (e || idx == 5) ? 6 : idx + 1;
      end
      if (p_we && p_addr[1:0] == 2'b00) begin
         int wi = p_addr >> 2;
         if (wi == 0) s_en = p_data[NUM-1:0];
         else if (wi <= 2 * NUM) begin
            if (wi % 2 == 1) s_hi[(wi-1)/2] = p_data[15:0];
            else             s_lo[(wi-1)/2] = p_data;
         end
      end
      p_we = 0;
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] dat);
      p_we = 1; p_addr = a; p_data = dat;
      cyc(0, 0, 0, 8'h00, "R2");
   endtask

   task automatic frame(input logic [47:0] a, input int len, input bit gap, input string tag);
      for (int i = 0; i < len; i++) begin
         cyc(1, i == 0, i == len - 1, (i < 6) ? a[47-8*i -: 8] : 8'(i), tag);
         if (gap && (i % 2 == 1)) cyc(0, 0, 0, 8'h5A, tag);
      end
      cyc(0, 0, 0, 8'h00, tag);
   endtask

   localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;
   localparam logic [47:0] STA = 48'h0211_2233_4455;
   localparam logic [47:0] LST = 48'hAABB_CCDD_EEFF;

   initial begin
      for (int k = 0; k < NUM; k++) begin s_hi[k] = 0; s_lo[k] = 0; a_hi[k] = 0; a_lo[k] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      @(negedge clk);
      // R1 reset state and empty table
      cyc(0, 0, 0, 8'h00, "R1 reset");
      frame(BC, 8, 0, "R1 empty table drops");
      // R2 program broadcast and station entries, R3 enable both
      wr(8'h04, 32'h0000_FFFF); wr(8'h08, 32'hFFFF_FFFF);
      wr(8'h0C, 32'h0000_0211); wr(8'h10, 32'h2233_4455);
      wr(8'h02, 32'h0001_FFFF);             // unaligned, ignored (R2)
      wr(8'h00, 32'h0001_8000);
      frame(BC, 10, 0, "R4 broadcast accept");
      frame(STA, 10, 0, "R4 station accept");
      frame(48'h0211_2233_4456, 10, 0, "R4 last byte differs");
      frame(48'h0311_2233_4455, 10, 0, "R4 first byte differs");
      frame(48'h1234_5678_9ABC, 7, 0, "R4 unknown drop");
      // R2/R3 last entry, enabled by bit 0
      wr(8'h84, 32'h0000_AABB); wr(8'h88, 32'hCCDD_EEFF);
      frame(LST, 8, 0, "R3 entry16 disabled");
      wr(8'h00, 32'h0001_8001);
      frame(LST, 8, 0, "R3 entry16 enabled");
      wr(8'h00, 32'h0000_0000);
      frame(STA, 8, 0, "R3 zero mask drops");
      // R6 promiscuous, R7 short even when promiscuous
      promisc = 1;
      frame(48'h1234_5678_9ABC, 9, 0, "R6 promisc accept");
      frame(48'h1234_5678_9ABC, 4, 0, "R7 short promisc drop");
      promisc = 0;
      wr(8'h00, 32'h0001_8000);
      // R8 write during frame
      cyc(1, 1, 0, STA[47:40], "R8 mid-frame write");
      cyc(1, 0, 0, STA[39:32], "R8 mid-frame write");
      p_we = 1; p_addr = 8'h10; p_data = 32'h0;
      cyc(1, 0, 0, STA[31:24], "R8 mid-frame write");
      cyc(1, 0, 0, STA[23:16], "R8 mid-frame write");
      cyc(1, 0, 0, STA[15:8], "R8 mid-frame write");
      cyc(1, 0, 1, STA[7:0], "R8 mid-frame write keeps old");
      cyc(0, 0, 0, 8'h00, "R8");
      frame(STA, 8, 0, "R8 new table at next sof");
      wr(8'h10, 32'h2233_4455);
      // R8 write on the sof cycle
      p_we = 1; p_addr = 8'h10; p_data = 32'h0;
      frame(STA, 8, 0, "R8 write on sof waits");
      frame(STA, 8, 0, "R8 write seen one frame later");
      wr(8'h10, 32'h2233_4455);
      // R9 gaps, stray bytes, restart
      frame(STA, 10, 1, "R9 gaps in address");
      for (int i = 0; i < 8; i++) cyc(1, 0, 0, STA[47:40], "R9 stray bytes");
      cyc(1, 1, 0, 8'h12, "R9 restart");
      cyc(1, 0, 0, 8'h34, "R9 restart");
      cyc(1, 0, 0, 8'h56, "R9 restart");
      frame(STA, 9, 0, "R9 restart accept");
      // R7 one-byte frame, R5 exactly six bytes, back to back
      cyc(1, 1, 1, 8'hFF, "R7 one-byte frame");
      frame(BC, 6, 0, "R5 six-byte frame");
      cyc(1, 1, 1, 8'hFF, "R7 back-to-back short");
      cyc(1, 1, 1, 8'h02, "R7 back-to-back short");
      frame(STA, 6, 0, "R5 back-to-back full");
      repeat (4) cyc(0, 0, 0, 8'h00, "R5 idle");
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule